// File: doc/BRIEF.md
# Receive FIFO with Overflow Lockout

This block sits between a serial receive shifter and the CPU. Each time the shifter finishes a frame it raises a one-cycle strobe with the received data, and the block writes the frame at its tail. The CPU takes entries from the head through a read strobe and sees the head entry on a data output. The storage is sixteen bytes, organised either as sixteen 8-bit entries or as four 32-bit entries, chosen by a mode input. Pointers wrap at the depth of the active mode.

When the fill level is at or above a programmable threshold, the block raises a receive-ready flag and a DMA request. If a frame completes while every entry is occupied, the frame is held back in the shifter and an overflow status bit latches. An error interrupt follows this status when its enable is set. While overflow is set, newly completed frames are discarded. The first CPU read frees a slot, clears the overflow, and moves the held frame into that slot. For debug, a halt input makes CPU reads non-destructive and allows the read pointer to be loaded directly. A synchronous clear empties the buffer.

Top module: `rx_fifo_lock`

## Requirements
- R1: A high `frame_valid` with storage available writes `frame_data` at the tail, and `level` rises by one on the next clock. Entries are read back in arrival order.
- R2: With `word_mode` = 0 the buffer holds 16 entries, stores only `frame_data[7:0]`, and presents the entry in `rd_data[7:0]` with `rd_data[31:8]` = 0. With `word_mode` = 1 it holds 4 entries of 32 bits.
- R3: A `cpu_rd` on a non-empty buffer (not halted) removes the head, and `level` falls by one on the next clock. A `cpu_rd` on an empty buffer changes nothing, and `level` stays 0.
- R4: `rxc` and `dma_req` are high exactly when `level` is non-zero and `level` >= `rx_thresh`. Both update on the same clock as `level`.
- R5: A `frame_valid` while the buffer is full and no read is taken sets `ovf` on the next clock, and that frame is held pending. While `ovf` is set, further `frame_valid` pulses are discarded and `level` does not change.
- R6: `err_irq` equals `ovf` AND `err_ie`, registered, so it follows a change of `err_ie` one clock later.
- R7: A read taken while `ovf` is set clears `ovf` and writes the pending frame at the tail. `level` stays at full depth, and the pending frame is read out after all older entries.
- R8: While `dbg_halt` = 1, `cpu_rd` moves neither the read pointer nor `level`. A `dbg_ptr_we` pulse loads `dbg_ptr` (masked to the mode depth) into the read pointer, so `rd_data` shows the entry at that index, and `level` is left unchanged.
- R9: `clr` (or `rst`) sets both pointers, `level`, `ovf` and the flags to 0 on the next clock, and drops any pending frame.
- R10: Both pointers wrap to 0 after the last entry of the active depth, so streaming more entries than the depth keeps the order intact.
- R11: A `frame_valid` and a taken read in the same cycle on a full buffer store the frame without setting `ovf`, and `level` stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous buffer clear |
| word_mode | input | 1 | 0: 16 x 8-bit entries, 1: 4 x 32-bit entries |
| frame_valid | input | 1 | One-cycle strobe: shifter holds a completed frame |
| frame_data | input | 32 | Completed frame from the shifter |
| cpu_rd | input | 1 | CPU read strobe for the head entry |
| rd_data | output | 32 | Entry at the read pointer |
| rx_thresh | input | 5 | Fill threshold for rxc and dma_req |
| rxc | output | 1 | Receive-ready flag |
| dma_req | output | 1 | Receive DMA request |
| level | output | 5 | Number of stored entries |
| ovf | output | 1 | Overflow status, latched |
| err_ie | input | 1 | Error interrupt enable |
| err_irq | output | 1 | Error interrupt |
| dbg_halt | input | 1 | Debug halt: reads do not consume |
| dbg_ptr_we | input | 1 | Load the read pointer while halted |
| dbg_ptr | input | 4 | Read pointer value to load |

## Verification
The bench fills the buffer to full depth in both modes and then sends frames past that point. A design that overwrote the head, or that counted beyond the depth, would return the wrong sequence or a level above 16 or 4. It checks that the frame which triggered overflow comes out last and that the frame arriving during lockout never appears. A design that dropped the held frame, or kept storing during lockout, breaks that order. A frame and a read in the same cycle on a full buffer must not raise overflow, which catches a fullness test that ignores the read. Halted reads and pointer loads are checked through `rd_data` and `level`: a design whose halted reads consume entries would lose data once the halt ends.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } rxf_mode_e;

  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned BYTE_DEPTH = 16,
  parameter int unsigned LANES      = 4
) (
  input  logic                              clk,
  input  logic                              word_mode,
  input  logic                              we,
  input  logic [$clog2(BYTE_DEPTH)-1:0]     wr_ptr,
  input  logic [LANES*LANE_BITS-1:0]        wdata,
  input  logic [$clog2(BYTE_DEPTH)-1:0]     rd_ptr,
  output logic [LANES*LANE_BITS-1:0]        rdata
);
  localparam int unsigned PW   = $clog2(BYTE_DEPTH);
  localparam int unsigned LW   = $clog2(LANES);
  localparam int unsigned ROWS = BYTE_DEPTH / LANES;
  localparam int unsigned RW   = $clog2(ROWS);
  localparam int unsigned DW   = LANES * LANE_BITS;

  logic [RW-1:0]        wrow, rrow;
  logic [LANE_BITS-1:0] lane_q [LANES];

  // byte mode: low pointer bits pick the lane, high bits the row
  // word mode: pointer is the row, every lane takes part
  assign wrow = (word_mode == MODE_WORD) ? wr_ptr[RW-1:0] : wr_ptr[PW-1:LW];
  assign rrow = (word_mode == MODE_WORD) ? rd_ptr[RW-1:0] : rd_ptr[PW-1:LW];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] mem [ROWS];
    logic                 lane_we;
    logic [LANE_BITS-1:0] lane_d;

    assign lane_we = we && ((word_mode == MODE_WORD) || (wr_ptr[LW-1:0] == LW'(l)));
    assign lane_d  = (word_mode == MODE_WORD) ? wdata[l*LANE_BITS +: LANE_BITS]
                                              : wdata[LANE_BITS-1:0];

    always_ff @(posedge clk) begin
      if (lane_we) mem[wrow] <= lane_d;
    end

    assign lane_q[l] = mem[rrow];
  end

  always_comb begin
    if (word_mode == MODE_WORD) begin
      for (int l = 0; l < LANES; l++) rdata[l*LANE_BITS +: LANE_BITS] = lane_q[l];
    end else begin
      rdata = '0;
      rdata[LANE_BITS-1:0] = lane_q[rd_ptr[LW-1:0]];
    end
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned BYTE_DEPTH = 16,
  parameter int unsigned LANES      = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              word_mode,
  input  logic                              frame_valid,
  input  logic [LANES*LANE_BITS-1:0]        frame_data,
  input  logic                              cpu_rd,
  input  logic                              dbg_halt,
  input  logic                              dbg_ptr_we,
  input  logic [$clog2(BYTE_DEPTH)-1:0]     dbg_ptr,
  output logic                              wr_en,
  output logic [$clog2(BYTE_DEPTH)-1:0]     wr_ptr,
  output logic [LANES*LANE_BITS-1:0]        wr_data,
  output logic [$clog2(BYTE_DEPTH)-1:0]     rd_ptr,
  output logic [$clog2(BYTE_DEPTH):0]       level,
  output logic [$clog2(BYTE_DEPTH):0]       level_nxt,
  output logic                              ovf,
  output logic                              ovf_nxt
);
  localparam int unsigned WORD_DEPTH = BYTE_DEPTH / LANES;
  localparam int unsigned PW = $clog2(BYTE_DEPTH);
  localparam int unsigned CW = PW + 1;
  localparam int unsigned DW = LANES * LANE_BITS;

  logic [CW-1:0] depth_cur;
  logic [PW-1:0] ptr_mask;
  logic          full, rd_fire, take_new, take_pend, ovf_set;
  logic [DW-1:0] pend_q;

  assign depth_cur = (word_mode == MODE_WORD) ? CW'(WORD_DEPTH) : CW'(BYTE_DEPTH);
  assign ptr_mask  = (word_mode == MODE_WORD) ? PW'(WORD_DEPTH - 1) : PW'(BYTE_DEPTH - 1);
  assign full      = (level == depth_cur);

  // reads consume only when not halted and something is stored
  assign rd_fire   = cpu_rd && !dbg_halt && (level != '0);
  // new frame goes in unless locked out or no slot frees this cycle
  assign take_new  = frame_valid && !ovf && (!full || rd_fire);
  // a read during lockout moves the held frame into the freed slot
  assign take_pend = ovf && rd_fire;
  assign ovf_set   = frame_valid && !ovf && full && !rd_fire;

  assign wr_en   = (take_new || take_pend) && !clr;
  assign wr_data = take_pend ? pend_q : frame_data;

  always_comb begin
    if (clr) begin
      level_nxt = '0;
      ovf_nxt   = 1'b0;
    end else begin
      level_nxt = level + CW'(take_new || take_pend) - CW'(rd_fire);
      if (ovf_set)        ovf_nxt = 1'b1;
      else if (take_pend) ovf_nxt = 1'b0;
      else                ovf_nxt = ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      pend_q <= '0;
    end else begin
      level <= level_nxt;
      ovf   <= ovf_nxt;
      if (wr_en) wr_ptr <= (wr_ptr + PW'(1)) & ptr_mask;
      if (dbg_halt && dbg_ptr_we) rd_ptr <= dbg_ptr & ptr_mask;
      else if (rd_fire)           rd_ptr <= (rd_ptr + PW'(1)) & ptr_mask;
      if (ovf_set) pend_q <= frame_data;
    end
  end

  AST_LOCKOUT_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(cpu_rd && !dbg_halt) && !clr) |=> $stable(level)); // R5

  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (level == depth_cur)); // R5

  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && level == '0 && !frame_valid && !clr && !dbg_ptr_we)
      |=> (level == '0) && $stable(rd_ptr)); // R3

  AST_HALT_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (dbg_halt && !dbg_ptr_we && !clr) |=> $stable(rd_ptr)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0) && !ovf && (rd_ptr == '0) && (wr_ptr == '0)); // R9

  AST_LEVEL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (level <= CW'(BYTE_DEPTH))); // R2
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level_nxt,
  input  logic [CW-1:0] rx_thresh,
  input  logic          ovf_nxt,
  input  logic          err_ie,
  output logic          rxc,
  output logic          dma_req,
  output logic          err_irq
);
  logic ready_nxt;

  assign ready_nxt = (level_nxt != '0) && (level_nxt >= rx_thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxc     <= 1'b0;
      dma_req <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      rxc     <= ready_nxt;
      dma_req <= ready_nxt;
      err_irq <= ovf_nxt && err_ie;
    end
  end
endmodule

// File: rtl/rx_fifo_lock.sv
module rx_fifo_lock
  import rxf_pkg::*;
#(
  parameter int unsigned BYTE_DEPTH = 16,
  parameter int unsigned LANES      = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                clr,
  input  logic                                word_mode,
  input  logic                                frame_valid,
  input  logic [LANES*LANE_BITS-1:0]          frame_data,
  input  logic                                cpu_rd,
  output logic [LANES*LANE_BITS-1:0]          rd_data,
  input  logic [$clog2(BYTE_DEPTH):0]         rx_thresh,
  output logic                                rxc,
  output logic                                dma_req,
  output logic [$clog2(BYTE_DEPTH):0]         level,
  output logic                                ovf,
  input  logic                                err_ie,
  output logic                                err_irq,
  input  logic                                dbg_halt,
  input  logic                                dbg_ptr_we,
  input  logic [$clog2(BYTE_DEPTH)-1:0]       dbg_ptr
);
  localparam int unsigned PW = $clog2(BYTE_DEPTH);
  localparam int unsigned CW = PW + 1;
  localparam int unsigned DW = LANES * LANE_BITS;

  logic          wr_en, ovf_nxt;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] level_nxt;

  rxf_ctrl #(.BYTE_DEPTH(BYTE_DEPTH), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .word_mode(word_mode),
    .frame_valid(frame_valid), .frame_data(frame_data), .cpu_rd(cpu_rd),
    .dbg_halt(dbg_halt), .dbg_ptr_we(dbg_ptr_we), .dbg_ptr(dbg_ptr),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data), .rd_ptr(rd_ptr),
    .level(level), .level_nxt(level_nxt), .ovf(ovf), .ovf_nxt(ovf_nxt)
  );

  rxf_store #(.BYTE_DEPTH(BYTE_DEPTH), .LANES(LANES)) u_store (
    .clk(clk), .word_mode(word_mode), .we(wr_en), .wr_ptr(wr_ptr),
    .wdata(wr_data), .rd_ptr(rd_ptr), .rdata(rd_data)
  );

  rxf_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .level_nxt(level_nxt), .rx_thresh(rx_thresh),
    .ovf_nxt(ovf_nxt), .err_ie(err_ie),
    .rxc(rxc), .dma_req(dma_req), .err_irq(err_irq)
  );

  AST_READY_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $stable(rx_thresh) |-> (rxc == ((level != '0) && (level >= rx_thresh)))); // R4

  AST_ERR_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> ovf); // R6
endmodule

// File: tb/rx_fifo_lock_test.sv
module rx_fifo_lock_test;
  logic        clk = 1'b0;
  logic        rst, clr, word_mode, frame_valid, cpu_rd, err_ie;
  logic        dbg_halt, dbg_ptr_we;
  logic [31:0] frame_data, rd_data;
  logic [4:0]  rx_thresh, level;
  logic [3:0]  dbg_ptr;
  logic        rxc, dma_req, ovf, err_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] sbq[$];

  always #4 clk = ~clk;

  rx_fifo_lock uut (
    .clk(clk), .rst(rst), .clr(clr), .word_mode(word_mode),
    .frame_valid(frame_valid), .frame_data(frame_data), .cpu_rd(cpu_rd),
    .rd_data(rd_data), .rx_thresh(rx_thresh), .rxc(rxc), .dma_req(dma_req),
    .level(level), .ovf(ovf), .err_ie(err_ie), .err_irq(err_irq),
    .dbg_halt(dbg_halt), .dbg_ptr_we(dbg_ptr_we), .dbg_ptr(dbg_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every consuming read pops the scoreboard (R1, R10 order)
  always @(negedge clk) begin
    if (!rst && !clr && cpu_rd && !dbg_halt && level != 0) begin
      if (sbq.size() == 0) chk("R1 unexpected read data", rd_data, 32'hxxxxxxxx);
      else chk("R1 read order", rd_data, sbq.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [31:0] d, input bit push);
    frame_valid = 1'b1; frame_data = d;
    tick();
    frame_valid = 1'b0;
    if (push) sbq.push_back(word_mode ? d : {24'h0, d[7:0]});
  endtask

  task automatic rd();
    cpu_rd = 1'b1;
    tick();
    cpu_rd = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    sbq.delete();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 0; word_mode = 0; frame_valid = 0; cpu_rd = 0; err_ie = 1;
    dbg_halt = 0; dbg_ptr_we = 0; dbg_ptr = 0; frame_data = 0; rx_thresh = 5'd3;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 reset level", level, 0);
    chk("R9 reset ovf", ovf, 0);
    chk("R9 reset rxc", rxc, 0);
    chk("R9 reset err_irq", err_irq, 0);

    // threshold and byte-mode masking
    send(32'hDEAD_BE11, 1); send(32'hCAFE_0022, 1);
    chk("R1 level after two", level, 2);
    chk("R4 rxc below threshold", rxc, 0);
    send(32'h1234_5633, 1);
    chk("R4 rxc at threshold", rxc, 1);
    chk("R4 dma at threshold", dma_req, 1);
    chk("R2 upper bits zero", rd_data, 32'h0000_0011);
    rd();
    chk("R3 level after read", level, 2);
    chk("R4 rxc drops below threshold", rxc, 0);
    rd(); rd();
    chk("R3 level empty", level, 0);
    rd();
    chk("R3 empty read keeps level", level, 0);

    // fill across the wrap point, then overflow
    rx_thresh = 5'd16;
    for (int i = 0; i < 16; i++) send(32'h100 + i, 1);
    chk("R2 byte depth full", level, 16);
    chk("R4 rxc full threshold", rxc, 1);
    chk("R5 no ovf at full", ovf, 0);
    send(32'h0000_00A5, 1);
    chk("R5 ovf set", ovf, 1);
    chk("R6 err_irq enabled", err_irq, 1);
    send(32'h0000_00B6, 0);
    chk("R5 level locked", level, 16);
    err_ie = 1'b0;
    tick();
    chk("R6 err_irq gated", err_irq, 0);
    err_ie = 1'b1;
    rd();
    chk("R7 ovf cleared by read", ovf, 0);
    chk("R7 level stays full", level, 16);
    for (int i = 0; i < 16; i++) rd();
    chk("R10 drained after wrap", level, 0);
    chk("R1 scoreboard empty", sbq.size(), 0);

    // simultaneous frame and read on a full buffer
    for (int i = 0; i < 16; i++) send(32'h40 + i, 1);
    frame_valid = 1'b1; frame_data = 32'h77; cpu_rd = 1'b1;
    tick();
    frame_valid = 1'b0; cpu_rd = 1'b0;
    sbq.push_back(32'h77);
    chk("R11 no ovf", ovf, 0);
    chk("R11 level full", level, 16);
    for (int i = 0; i < 16; i++) rd();
    chk("R11 drained", sbq.size(), 0);

    // debug halt
    do_clr();
    rx_thresh = 5'd1;
    send(32'hA0, 1); send(32'hA1, 1); send(32'hA2, 1); send(32'hA3, 1);
    dbg_halt = 1'b1;
    rd();
    chk("R8 halted read keeps level", level, 4);
    chk("R8 halted read keeps head", rd_data, 32'hA0);
    dbg_ptr = 4'd2; dbg_ptr_we = 1'b1;
    tick();
    dbg_ptr_we = 1'b0;
    chk("R8 pointer load", rd_data, 32'hA2);
    chk("R8 load keeps level", level, 4);
    dbg_ptr = 4'd0; dbg_ptr_we = 1'b1;
    tick();
    dbg_ptr_we = 1'b0; dbg_halt = 1'b0;
    for (int i = 0; i < 4; i++) rd();
    chk("R8 drained after halt", sbq.size(), 0);

    // clear while locked out
    for (int i = 0; i < 17; i++) send(32'h200 + i, 0);
    chk("R5 ovf before clear", ovf, 1);
    do_clr();
    chk("R9 clear level", level, 0);
    chk("R9 clear ovf", ovf, 0);
    chk("R9 clear rxc", rxc, 0);

    // word mode
    word_mode = 1'b1; rx_thresh = 5'd4;
    tick();
    for (int i = 0; i < 4; i++) send(32'h1111_1111 * (i + 1), 1);
    chk("R2 word depth full", level, 4);
    chk("R4 word rxc", rxc, 1);
    send(32'h5555_AAAA, 1);
    chk("R5 word ovf", ovf, 1);
    send(32'h6666_0000, 0);
    rd();
    chk("R7 word ovf cleared", ovf, 0);
    chk("R7 word level", level, 4);
    for (int i = 0; i < 4; i++) rd();
    chk("R2 word drained", level, 0);
    chk("R10 word scoreboard empty", sbq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule